// File: doc/BRIEF.md
# Complex Rotator Multiply-Accumulate with Selectable Output Fields

This block rotates an external complex sample by a (cosine, sine) vector supplied each clock. It computes the complex product and can sum successive products for an accumulate-and-dump filter. Typical uses are quadrature down-conversion and modulation, with the rotation vector coming from a neighbouring oscillator. Before the multiplier, a programmable shifter takes a 16-bit window from a 19-bit latched sample. A second, narrower complex accumulator sums the windowed samples directly. It runs in parallel with the main accumulator and shares the same accumulate and dump control.

An output selector chooses what appears on the two 20-bit ports. It can show the upper bit field of the main accumulator, or a low bit field with a zero inserted at a fixed position, or the narrow accumulator. A format select gives either two's complement or offset binary, in which the top bit is inverted. The selector and the format select act in the same cycle. The sample path has a fixed depth of four clocks.

Top module: `rotmac_top`

## Requirements
- R1: A sample, shift code, rotation vector and accumulate control presented at one rising edge reach the accumulators at the fourth rising edge, so the outputs show the result after four clocks. A synchronous active-low reset clears every register, which makes both outputs zero in two's complement with selector code 00.
- R2: The input sample registers take a new sample only when the registered active-low enable was low. When the enable was high they keep their previous sample, whatever the sample inputs carry.
- R3: Shift code 0, 1, 2 or 3 takes bits 0–15, 1–16, 2–17 or 3–18 of the latched 19-bit sample as the signed 16-bit operand. The same window is applied to the real and the imaginary part.
- R4: The product is real = cos·x − sin·y and imaginary = cos·y + sin·x. Here x and y are the windowed real and imaginary operands, and all values are signed. Each product is 33 bits wide, and no product exceeds 2^31 in magnitude.
- R5: When the accumulate control is high, the 35-bit signed main accumulator adds the product to its value and wraps on overflow. When it is low, the accumulator loads the product, sign-extended, with its old value discarded.
- R6: Selector code 00 drives main accumulator bits 34–15 onto output bits 19–0.
- R7: Selector code 01 drives main accumulator bits 34–31 onto output bits 19–16. Output bit 15 is zero, and accumulator bits 14–0 go to output bits 14–0.
- R8: Selector code 10 drives the 20-bit auxiliary accumulator. It sums or loads the sign-extended windowed samples under the same accumulate control and timing as R5, and wraps at 20 bits.
- R9: Selector code 11 drives zero on both outputs, for either format.
- R10: With the format select at 1, the outputs are two's complement. With it at 0, output bit 19 of both ports is inverted for selector codes 00, 01 and 10.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| smp_re | input | 19 | Real part of the input sample |
| smp_im | input | 19 | Imaginary part of the input sample |
| win_sel | input | 2 | Shift code selecting the 16-bit operand window |
| smp_en_n | input | 1 | Sample load enable, active low, registered |
| rot_cos | input | 16 | Signed cosine of the rotation vector |
| rot_sin | input | 16 | Signed sine of the rotation vector |
| acc_en | input | 1 | 1 = accumulate, 0 = dump (load product) |
| out_sel | input | 2 | Output field selector (00 high, 01 low, 10 auxiliary, 11 zero) |
| twos_cmp | input | 1 | 1 = two's complement, 0 = offset binary |
| out_re | output | 20 | Real output word |
| out_im | output | 20 | Imaginary output word |

## Verification
The hardest case to reach is wrap-around in both accumulators. The main accumulator has two guard bits above the widest product, so it wraps only after many near-full-scale products, and the auxiliary accumulator wraps at 20 bits. To reach it, the stimulus holds the largest negative operand and cosine with the sine at zero. It issues one dump and then sixteen accumulate cycles, and reads both fields at the exact cycle the seventeenth term lands, switching the selector within that cycle. A second hard case is the hold of R2. The enable is raised in the same cycle that a different sample is applied, and the outputs are checked after the full pipeline depth to show that the old sample was kept.

// File: rtl/rotmac_pkg.sv
// Shared types for the complex rotator multiply-accumulate block.
// Assumes: selector encoding below is fixed and decoded by rotmac_outfmt.
package rotmac_pkg;
    typedef enum logic [1:0] {
        OSEL_HIGH = 2'b00,
        OSEL_LOW  = 2'b01,
        OSEL_AUX  = 2'b10,
        OSEL_RSVD = 2'b11
    } osel_e;
endpackage

// File: rtl/rotmac_inreg.sv
// Input capture and window shifter.
// Registers the sample, its enable and the shift code. The sample holding
// registers load one clock later, and only if the registered enable was low.
// The windowed operands are combinational from the holding registers, using
// a shift code delayed to stay aligned with them.
// Assumes: IN_W = WIN_W + 2**SH_W - 1.
module rotmac_inreg #(
    parameter int WIN_W = 16,
    parameter int SH_W  = 2,
    parameter int IN_W  = WIN_W + (1 << SH_W) - 1
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    en_n,
    input  logic [IN_W-1:0]         rin,
    input  logic [IN_W-1:0]         iin,
    input  logic [SH_W-1:0]         sh,
    output logic signed [WIN_W-1:0] win_re,
    output logic signed [WIN_W-1:0] win_im
);
    logic            en_q;
    logic [IN_W-1:0] rin_q, iin_q;
    logic [IN_W-1:0] rin_r, iin_r;
    logic [SH_W-1:0] sh_q1, sh_q2;

    // Stage 1: capture the port values and the enable.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q  <= 1'b1;
            rin_q <= '0;
            iin_q <= '0;
            sh_q1 <= '0;
        end else begin
            en_q  <= en_n;
            rin_q <= rin;
            iin_q <= iin;
            sh_q1 <= sh;
        end
    end

    // Stage 2: the holding registers load under the registered enable.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rin_r <= '0;
            iin_r <= '0;
            sh_q2 <= '0;
        end else begin
            sh_q2 <= sh_q1;
            if (!en_q) begin
                rin_r <= rin_q;
                iin_r <= iin_q;
            end
        end
    end

    // Window select on the held sample.
    always_comb begin
        win_re = rin_r[sh_q2 +: WIN_W];
        win_im = iin_r[sh_q2 +: WIN_W];
    end

    AST_HOLD_WHEN_DISABLED: assert property (@(posedge clk) disable iff (!rst_n)
        en_q |=> ($stable(rin_r) && $stable(iin_r))); // R2
endmodule

// File: rtl/rotmac_cmul.sv
// Registered complex multiplier: re = c*x - s*y, im = c*y + s*x.
// Assumes: all operands are signed. The result is one bit wider than the
// sum of the operand widths, so it cannot overflow.
module rotmac_cmul #(
    parameter int WIN_W  = 16,
    parameter int TRIG_W = 16,
    parameter int PROD_W = WIN_W + TRIG_W + 1
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic signed [WIN_W-1:0]  x_re,
    input  logic signed [WIN_W-1:0]  x_im,
    input  logic signed [TRIG_W-1:0] c,
    input  logic signed [TRIG_W-1:0] s,
    output logic signed [PROD_W-1:0] p_re,
    output logic signed [PROD_W-1:0] p_im
);
    localparam int MUL_W = WIN_W + TRIG_W;
    localparam logic signed [PROD_W-1:0] P_MAX = {2'b01, {(PROD_W-2){1'b0}}};
    localparam logic signed [PROD_W-1:0] P_MIN = -P_MAX;

    logic signed [MUL_W-1:0]  m_cx, m_sy, m_cy, m_sx;
    logic signed [PROD_W-1:0] sum_re, sum_im;

    // Four partial products, then the complex combination.
    always_comb begin
        m_cx   = c * x_re;
        m_sy   = s * x_im;
        m_cy   = c * x_im;
        m_sx   = s * x_re;
        sum_re = PROD_W'(m_cx) - PROD_W'(m_sy);
        sum_im = PROD_W'(m_cy) + PROD_W'(m_sx);
    end

    // Product register stage ahead of the accumulators.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            p_re <= '0;
            p_im <= '0;
        end else begin
            p_re <= sum_re;
            p_im <= sum_im;
        end
    end

    AST_PROD_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (p_re <= P_MAX) && (p_re >= P_MIN) && (p_im <= P_MAX) && (p_im >= P_MIN)); // R4
endmodule

// File: rtl/rotmac_accum.sv
// Accumulate-and-dump register with wrap-around.
// acc_en high: add the sign-extended input to the register.
// acc_en low:  load the sign-extended input, discarding the old value.
// Assumes: AW >= DW.
module rotmac_accum #(
    parameter int DW = 33,
    parameter int AW = 35
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 acc_en,
    input  logic signed [DW-1:0] din,
    output logic signed [AW-1:0] acc
);
    // Feedback is gated by acc_en.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc <= '0;
        end else if (acc_en) begin
            acc <= acc + AW'(din);
        end else begin
            acc <= AW'(din);
        end
    end

    AST_DUMP_LOADS_INPUT: assert property (@(posedge clk) disable iff (!rst_n)
        !acc_en |=> (acc == AW'($past(din)))); // R5
endmodule

// File: rtl/rotmac_outfmt.sv
// Output field selector and number-format stage for one lane.
// Selects a bit field of the main accumulator, the auxiliary accumulator,
// or zero, then optionally inverts the top bit for offset binary.
// Assumes: ACC_W > OUT_W and AUX_W == OUT_W.
module rotmac_outfmt
    import rotmac_pkg::*;
#(
    parameter int ACC_W = 35,
    parameter int OUT_W = 20
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [1:0]       sel,
    input  logic             twos,
    input  logic [ACC_W-1:0] acc_main,
    input  logic [OUT_W-1:0] acc_aux,
    output logic [OUT_W-1:0] dout
);
    localparam int LO_W = ACC_W - OUT_W;
    localparam int HI_W = OUT_W - 1 - LO_W;

    logic [OUT_W-1:0] field;
    osel_e            osel;

    // Field select by selector code.
    always_comb begin
        osel = osel_e'(sel);
        unique case (osel)
            OSEL_HIGH: field = acc_main[ACC_W-1 -: OUT_W];
            OSEL_LOW:  field = {acc_main[ACC_W-1 -: HI_W], 1'b0, acc_main[LO_W-1:0]};
            OSEL_AUX:  field = acc_aux;
            default:   field = '0;
        endcase
    end

    // Offset-binary conversion, not applied to the zero code.
    always_comb begin
        dout = field;
        if (!twos && (osel != OSEL_RSVD)) begin
            dout[OUT_W-1] = ~field[OUT_W-1];
        end
    end

    AST_RESERVED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (sel == 2'b11) |-> (dout == '0)); // R9
endmodule

// File: rtl/rotmac_top.sv
// Complex rotator multiply-accumulate, top level.
// Sample path: port capture -> holding register -> product register ->
// accumulators, four clocks in all. The rotation vector and accumulate
// control are delayed to match. The output selector and format act
// combinationally on the accumulator registers.
// Assumes: synchronous active-low reset; all arithmetic is signed.
module rotmac_top #(
    parameter  int WIN_W     = 16,
    parameter  int SH_W      = 2,
    parameter  int TRIG_W    = 16,
    parameter  int ACC_GUARD = 2,
    parameter  int OUT_W     = 20,
    localparam int IN_W      = WIN_W + (1 << SH_W) - 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [IN_W-1:0]   smp_re,
    input  logic [IN_W-1:0]   smp_im,
    input  logic [SH_W-1:0]   win_sel,
    input  logic              smp_en_n,
    input  logic [TRIG_W-1:0] rot_cos,
    input  logic [TRIG_W-1:0] rot_sin,
    input  logic              acc_en,
    input  logic [1:0]        out_sel,
    input  logic              twos_cmp,
    output logic [OUT_W-1:0]  out_re,
    output logic [OUT_W-1:0]  out_im
);
    localparam int PROD_W = WIN_W + TRIG_W + 1;
    localparam int ACC_W  = PROD_W + ACC_GUARD;
    localparam int AUX_W  = OUT_W;
    localparam int LANES  = 2;

    logic signed [WIN_W-1:0]  win_re, win_im;
    logic signed [TRIG_W-1:0] cos_q1, cos_q2, sin_q1, sin_q2;
    logic [2:0]               acc_pipe;
    logic signed [WIN_W-1:0]  aux_d   [LANES];
    logic signed [PROD_W-1:0] prod    [LANES];
    logic signed [ACC_W-1:0]  acc_m   [LANES];
    logic signed [AUX_W-1:0]  acc_a   [LANES];
    logic [OUT_W-1:0]         lane_out[LANES];

    rotmac_inreg #(.WIN_W(WIN_W), .SH_W(SH_W), .IN_W(IN_W)) u_inreg (
        .clk    (clk),
        .rst_n  (rst_n),
        .en_n   (smp_en_n),
        .rin    (smp_re),
        .iin    (smp_im),
        .sh     (win_sel),
        .win_re (win_re),
        .win_im (win_im)
    );

    // Delay the rotation vector, accumulate control and windowed samples to match the data.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cos_q1   <= '0;
            cos_q2   <= '0;
            sin_q1   <= '0;
            sin_q2   <= '0;
            acc_pipe <= '0;
            aux_d[0] <= '0;
            aux_d[1] <= '0;
        end else begin
            cos_q1   <= rot_cos;
            cos_q2   <= cos_q1;
            sin_q1   <= rot_sin;
            sin_q2   <= sin_q1;
            acc_pipe <= {acc_pipe[1:0], acc_en};
            aux_d[0] <= win_re;
            aux_d[1] <= win_im;
        end
    end

    rotmac_cmul #(.WIN_W(WIN_W), .TRIG_W(TRIG_W), .PROD_W(PROD_W)) u_cmul (
        .clk   (clk),
        .rst_n (rst_n),
        .x_re  (win_re),
        .x_im  (win_im),
        .c     (cos_q2),
        .s     (sin_q2),
        .p_re  (prod[0]),
        .p_im  (prod[1])
    );

    // One main accumulator, one auxiliary accumulator and one formatter per lane.
    for (genvar ln = 0; ln < LANES; ln++) begin : g_lane
        rotmac_accum #(.DW(PROD_W), .AW(ACC_W)) u_acc_main (
            .clk    (clk),
            .rst_n  (rst_n),
            .acc_en (acc_pipe[2]),
            .din    (prod[ln]),
            .acc    (acc_m[ln])
        );
        rotmac_accum #(.DW(WIN_W), .AW(AUX_W)) u_acc_aux (
            .clk    (clk),
            .rst_n  (rst_n),
            .acc_en (acc_pipe[2]),
            .din    (aux_d[ln]),
            .acc    (acc_a[ln])
        );
        rotmac_outfmt #(.ACC_W(ACC_W), .OUT_W(OUT_W)) u_fmt (
            .clk      (clk),
            .rst_n    (rst_n),
            .sel      (out_sel),
            .twos     (twos_cmp),
            .acc_main (acc_m[ln]),
            .acc_aux  (acc_a[ln]),
            .dout     (lane_out[ln])
        );
    end

    assign out_re = lane_out[0];
    assign out_im = lane_out[1];

    AST_FMT_TOP_BIT: assert property (@(posedge clk) disable iff (!rst_n)
        (out_sel == 2'b00) |-> (out_re[OUT_W-1] == (acc_m[0][ACC_W-1] ^ !twos_cmp))); // R10
endmodule

// File: tb/rotmac_top_tb.sv
// Directed bench for rotmac_top: one task per scenario, each checking its results.
module rotmac_top_tb;
    logic        clk = 1'b0;
    logic        rst_n;
    logic [18:0] b_re, b_im;
    logic [1:0]  b_sh;
    logic        b_en_n;
    logic [15:0] b_c, b_s;
    logic        b_acc;
    logic [1:0]  b_sel;
    logic        b_twos;
    logic [19:0] o_re, o_im;
    int checks   = 0;
    int failures = 0;

    always #10 clk = ~clk;

    rotmac_top u_dut (
        .clk      (clk),
        .rst_n    (rst_n),
        .smp_re   (b_re),
        .smp_im   (b_im),
        .win_sel  (b_sh),
        .smp_en_n (b_en_n),
        .rot_cos  (b_c),
        .rot_sin  (b_s),
        .acc_en   (b_acc),
        .out_sel  (b_sel),
        .twos_cmp (b_twos),
        .out_re   (o_re),
        .out_im   (o_im)
    );

    task automatic chk(input string tag, input logic [19:0] act, input logic [19:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    function automatic logic signed [15:0] win16(input logic [18:0] v, input logic [1:0] sh);
        return v[sh +: 16];
    endfunction

    function automatic logic signed [34:0] prod(input bit imag);
        logic signed [15:0] x, y, c, s;
        x = win16(b_re, b_sh);
        y = win16(b_im, b_sh);
        c = b_c;
        s = b_s;
        if (imag) return 35'(c) * 35'(y) + 35'(s) * 35'(x);
        return 35'(c) * 35'(x) - 35'(s) * 35'(y);
    endfunction

    function automatic logic [19:0] hi(input logic [34:0] a);
        return a[34:15];
    endfunction

    function automatic logic [19:0] lo(input logic [34:0] a);
        return {a[34:31], 1'b0, a[14:0]};
    endfunction

    task automatic drive(input logic [18:0] re, input logic [18:0] im, input logic [1:0] sh,
                         input logic [15:0] c, input logic [15:0] s);
        b_re = re; b_im = im; b_sh = sh; b_c = c; b_s = s;
    endtask

    task automatic t_reset();
        b_sel = 2'b00; b_twos = 1'b1;
        #1 chk("R1 reset re", o_re, 20'h0);
        chk("R1 reset im", o_im, 20'h0);
        b_twos = 1'b0;
        #1 chk("R1 reset offset re", o_re, 20'h80000);
        b_twos = 1'b1;
    endtask

    task automatic t_dump(input logic [18:0] re, input logic [18:0] im,
                          input logic [15:0] c, input logic [15:0] s);
        drive(re, im, 2'd0, c, s);
        tick(5);
        chk("R4 R6 dump re", o_re, hi(prod(0)));
        chk("R4 R6 dump im", o_im, hi(prod(1)));
    endtask

    task automatic t_latency();
        logic [19:0] old_re, new_re;
        drive(19'd3000, 19'd500, 2'd0, 16'd30000, 16'd7000);
        tick(5);
        old_re = hi(prod(0));
        drive(19'h7F000, 19'd2500, 2'd0, 16'hA000, 16'd12000);
        new_re = hi(prod(0));
        tick(3);
        chk("R1 three clocks keeps old", o_re, old_re);
        tick(1);
        chk("R1 fourth clock shows new", o_re, new_re);
    endtask

    task automatic t_lowfield();
        drive(19'd1234, 19'h7EDCB, 2'd0, 16'd321, 16'hFF37);
        tick(5);
        b_sel = 2'b01;
        #1 chk("R7 low field re", o_re, lo(prod(0)));
        chk("R7 low field im", o_im, lo(prod(1)));
        b_sel = 2'b00;
    endtask

    task automatic t_shift();
        for (int k = 0; k < 4; k++) begin
            drive(19'h6B3C5, 19'h1F0A7, 2'(k), 16'd9000, 16'hD000);
            tick(5);
            chk("R3 window product re", o_re, hi(prod(0)));
            b_sel = 2'b10;
            #1 chk("R3 R8 window aux re", o_re, 20'(win16(b_re, b_sh)));
            chk("R3 R8 window aux im", o_im, 20'(win16(b_im, b_sh)));
            b_sel = 2'b00;
        end
    endtask

    task automatic t_hold();
        logic [19:0] kept;
        drive(19'd4000, 19'd100, 2'd0, 16'd15000, 16'd2000);
        tick(5);
        kept = hi(prod(0));
        b_en_n = 1'b1;
        b_re = 19'h40000;
        b_im = 19'h2AAAA;
        tick(5);
        chk("R2 held sample product", o_re, kept);
        b_sel = 2'b10;
        #1 chk("R2 held sample aux", o_re, 20'd4000);
        b_sel = 2'b00;
        b_en_n = 1'b0;
        tick(5);
        chk("R2 new sample after enable", o_re, hi(prod(0)));
    endtask

    task automatic t_accum(input int n, input logic [18:0] re, input logic [15:0] c,
                           input logic [15:0] s);
        logic signed [34:0] e_main;
        logic signed [19:0] e_aux;
        drive(re, 19'd777, 2'd0, c, s);
        b_acc = 1'b0;
        tick(5);
        e_main = prod(0) * 35'(n + 1);
        e_aux  = 20'(win16(b_re, b_sh)) * 20'(n + 1);
        b_acc = 1'b1;
        tick(n + 3);
        chk("R5 accumulated main re", o_re, hi(e_main));
        b_sel = 2'b10;
        #1 chk("R8 accumulated aux re", o_re, e_aux);
        b_sel = 2'b00;
        b_acc = 1'b0;
        tick(4);
        chk("R5 dump after accumulate", o_re, hi(prod(0)));
    endtask

    task automatic t_rsvd();
        b_sel = 2'b11; b_twos = 1'b1;
        #1 chk("R9 reserved re", o_re, 20'h0);
        chk("R9 reserved im", o_im, 20'h0);
        b_twos = 1'b0;
        #1 chk("R9 reserved offset re", o_re, 20'h0);
        b_sel = 2'b00; b_twos = 1'b1;
    endtask

    task automatic t_fmt();
        drive(19'd2222, 19'h7F111, 2'd0, 16'd25000, 16'd4000);
        tick(5);
        b_twos = 1'b0;
        #1 chk("R10 offset re", o_re, hi(prod(0)) ^ 20'h80000);
        chk("R10 offset im", o_im, hi(prod(1)) ^ 20'h80000);
        b_sel = 2'b10;
        #1 chk("R10 offset aux", o_re, 20'd2222 ^ 20'h80000);
        b_sel = 2'b00; b_twos = 1'b1;
    endtask

    initial begin
        #4_000_000;
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        rst_n = 1'b0;
        b_en_n = 1'b0; b_acc = 1'b0; b_sel = 2'b00; b_twos = 1'b1;
        drive(19'd0, 19'd0, 2'd0, 16'd0, 16'd0);
        tick(3);
        t_reset();
        rst_n = 1'b1;
        tick(1);
        t_dump(19'd1000, 19'h7F830, 16'd20000, 16'hD120);
        t_dump(19'h78000, 19'h07FFF, 16'h8000, 16'h8000);
        t_dump(19'd12345, 19'd23456, 16'd32767, 16'd32767);
        t_latency();
        t_lowfield();
        t_shift();
        t_hold();
        t_accum(3, 19'd5000, 16'd21000, 16'hE000);
        t_accum(16, 19'h78000, 16'h8000, 16'h0000);
        t_rsvd();
        t_fmt();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule